// File: doc/BRIEF.md
# Dual-format FP8 to fixed-point converter

This block turns an 8-bit floating-point word into a signed two's-complement fixed-point word in the same cycle. A single select input chooses how the byte is read. With the select high, the byte has four exponent bits and three mantissa bits. With the select low, it has five exponent bits and two mantissa bits. The select also moves the binary point of the 32-bit result. The narrow-exponent format produces 9 fraction bits. The wide-exponent format produces 16 fraction bits.

One exponent decoder and one barrel shifter serve both formats. The decoder re-expresses either encoding as a 4-bit significand with three fraction bits and a single left-shift count. A finishing stage then applies the sign, and it saturates values that do not fit in 32 bits. The block has no clock and no reset. Its output follows its inputs combinationally.

Top module: `fp8_fixed_conv`

## Requirements
- R1: With `mode_e4m3`=1, bit 7 is the sign, bits [6:3] the exponent (bias 7) and bits [2:0] the mantissa. A nonzero exponent e gives magnitude (1 + m/8)·2^(e−7). `fixed_out` holds that value times 2^9 (Q23.9).
- R2: With `mode_e4m3`=0, bit 7 is the sign, bits [6:2] the exponent (bias 15) and bits [1:0] the mantissa. A nonzero exponent e gives magnitude (1 + m/4)·2^(e−15). `fixed_out` holds that value times 2^16 (Q16.16).
- R3: An exponent field of zero encodes a subnormal (m/8)·2^−6 or (m/4)·2^−14. Code 0x01 yields exactly 1 LSB in either mode (2^−9 and 2^−16).
- R4: When bit 7 is set, the output is the two's-complement negation of the magnitude.
- R5: Codes 0x00 and 0x80 both give an all-zero output in both modes.
- R6: In the 4-exponent-bit mode, every result fits, and bits [31:18] are all copies of the sign.
- R7: In the 5-exponent-bit mode, a magnitude of 2^15 or more (exponent field 30 or 31) saturates to 0x7FFFFFFF when positive and to 0x80000000 when negative.
- R8: All-ones exponent codes are converted as ordinary finite values. In the 4-exponent-bit mode, 0x7F gives 480.0 (0x0003C000). In the 5-exponent-bit mode, they fall under R7.
- R9: The output reflects a change of input in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fp8_in | input | 8 | Floating-point code to convert |
| mode_e4m3 | input | 1 | 1: 4-exponent-bit format to Q23.9; 0: 5-exponent-bit format to Q16.16 |
| fixed_out | output | 32 | Signed two's-complement fixed-point result |

## Verification
The block holds no state, so a wrong shift count, a wrong hidden bit or a wrong bias correction appears at `fixed_out` in the same cycle as the offending code. A shift count that is off by one doubles or halves the result. A missing hidden bit drops the leading term. A bad overflow decode in the wide mode shows up as a wrapped sign instead of a clamp. Every code in both modes is compared against a real-number model, so each such fault appears on the first code that exercises it.

// File: rtl/fp8fx_pkg.sv
package fp8fx_pkg;
  localparam int CODE_W  = 8;
  localparam int SIG_W   = 4;   // hidden bit + three fraction bits
  localparam int SH_W    = 5;   // shift count width
  localparam int MAX_SH  = 30;  // largest shift reached by any code
  localparam int PROD_W  = SIG_W + MAX_SH;

  typedef struct packed {
    logic             neg;
    logic [SIG_W-1:0] sig;
    logic [SH_W-1:0]  shamt;
  } fp8fx_unp_t;

  // Exponent field widened to five bits for either format
  function automatic logic [SH_W-1:0] exp_field(input logic [CODE_W-1:0] c, input logic narrow);
    return narrow ? {1'b0, c[6:3]} : c[6:2];
  endfunction

  // Mantissa aligned to three fraction bits for either format
  function automatic logic [2:0] man_field(input logic [CODE_W-1:0] c, input logic narrow);
    return narrow ? c[2:0] : {c[1:0], 1'b0};
  endfunction
endpackage

// File: rtl/fp8fx_unpack.sv
module fp8fx_unpack
  import fp8fx_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              narrow,
  output fp8fx_unp_t        unp
);
  logic [SH_W-1:0] expf;
  logic [SH_W-1:0] eeff;
  logic            hidden;

  always_comb begin
    expf   = exp_field(code, narrow);
    hidden = (expf != '0);
    eeff   = hidden ? expf : SH_W'(1);
    unp.neg   = code[CODE_W-1];
    unp.sig   = {hidden, man_field(code, narrow)};
    // shift so that (sig << shamt) >> 1 lands on the output LSB grid
    unp.shamt = narrow ? eeff : eeff - SH_W'(1);
  end
endmodule

// File: rtl/fp8fx_shift.sv
module fp8fx_shift
  import fp8fx_pkg::*;
#(
  parameter int IN_W  = SIG_W,
  parameter int SHW   = SH_W,
  parameter int OUT_W = PROD_W
) (
  input  logic [IN_W-1:0]  din,
  input  logic [SHW-1:0]   amt,
  output logic [OUT_W-1:0] dout
);
  logic [OUT_W-1:0] stg [0:SHW];

  assign stg[0] = OUT_W'(din);

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    assign stg[k+1] = amt[k] ? (stg[k] << (1 << k)) : stg[k];
  end

  assign dout = stg[SHW];
endmodule

// File: rtl/fp8fx_finish.sv
module fp8fx_finish
  import fp8fx_pkg::*;
#(
  parameter int IN_W  = PROD_W,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  prod,
  input  logic             neg,
  output logic [OUT_W-1:0] result,
  output logic             ovf
);
  localparam int MAG_W = IN_W - 1;
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [MAG_W-1:0] mag;
  logic [OUT_W-1:0] low;

  always_comb begin
    mag = prod[IN_W-1:1];
    low = mag[OUT_W-1:0];
    ovf = |mag[MAG_W-1:OUT_W-1];
    if (ovf)      result = neg ? NEG_MIN : POS_MAX;
    else if (neg) result = -low;
    else          result = low;
  end
endmodule

// File: rtl/fp8_fixed_conv.sv
module fp8_fixed_conv
  import fp8fx_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic [7:0]       fp8_in,
  input  logic             mode_e4m3,
  output logic [OUT_W-1:0] fixed_out
);
  fp8fx_unp_t        unp;
  logic [PROD_W-1:0] prod;
  logic              ovf;

  fp8fx_unpack u_unpack (
    .code   (fp8_in),
    .narrow (mode_e4m3),
    .unp    (unp)
  );

  fp8fx_shift #(.IN_W(SIG_W), .SHW(SH_W), .OUT_W(PROD_W)) u_shift (
    .din  (unp.sig),
    .amt  (unp.shamt),
    .dout (prod)
  );

  fp8fx_finish #(.IN_W(PROD_W), .OUT_W(OUT_W)) u_finish (
    .prod   (prod),
    .neg    (unp.neg),
    .result (fixed_out),
    .ovf    (ovf)
  );
endmodule

// File: rtl/fp8_fixed_conv_chk.sv
module fp8_fixed_conv_chk (
  input logic [7:0]  fp8_in,
  input logic        mode_e4m3,
  input logic [31:0] fixed_out,
  input logic        ovf
);
  always_comb begin
    if (fp8_in[6:0] == 7'd0)
      assert_zero_R5: assert (fixed_out == 32'd0)
        else $error("zero code gave nonzero output");
    if (fp8_in[6:0] != 7'd0)
      assert_sign_R4: assert (fixed_out[31] == fp8_in[7])
        else $error("output sign disagrees with code sign");
    if (fp8_in[6:0] == 7'd1)
      assert_lsb_R3: assert (fixed_out == (fp8_in[7] ? 32'hFFFF_FFFF : 32'd1))
        else $error("smallest subnormal not on LSB");
    if (mode_e4m3)
      assert_extend_R6: assert ($countones(fixed_out[31:18]) == 0 || $countones(fixed_out[31:18]) == 14)
        else $error("narrow mode result not sign extended");
    if (ovf)
      assert_no_overflow_R6: assert (!mode_e4m3)
        else $error("overflow flagged in narrow mode");
    if (!mode_e4m3 && fp8_in[6:2] >= 5'd30)
      assert_saturate_R7: assert (fixed_out == (fp8_in[7] ? 32'h8000_0000 : 32'h7FFF_FFFF))
        else $error("wide mode large value not clamped");
  end
endmodule

bind fp8_fixed_conv fp8_fixed_conv_chk u_chk (
  .fp8_in    (fp8_in),
  .mode_e4m3 (mode_e4m3),
  .fixed_out (fixed_out),
  .ovf       (ovf)
);

// File: tb/fp8_fixed_conv_test.sv
`timescale 1ns/1ps
module fp8_fixed_conv_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  fp8_in = 8'h00;
  logic        mode_e4m3 = 1'b1;
  logic [31:0] fixed_out;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  fp8_fixed_conv uut (
    .fp8_in    (fp8_in),
    .mode_e4m3 (mode_e4m3),
    .fixed_out (fixed_out)
  );

  // Real-number reference: decode, scale, sign, clamp
  function automatic longint model(input bit [7:0] c, input bit narrow);
    int  e, m, bias, mbits, fbits, expo;
    real frac, v;
    longint r;
    if (narrow) begin e = c[6:3]; m = c[2:0]; bias = 7;  mbits = 3; fbits = 9;  end
    else        begin e = c[6:2]; m = c[1:0]; bias = 15; mbits = 2; fbits = 16; end
    frac = real'(m) / (2.0 ** mbits);
    if (e == 0) begin expo = 1 - bias; v = frac; end
    else        begin expo = e - bias; v = 1.0 + frac; end
    v = v * (2.0 ** (expo + fbits));
    r = longint'(v);
    if (c[7]) r = -r;
    if (r > 64'sd2147483647)  r = 64'sd2147483647;
    if (r < -64'sd2147483648) r = -64'sd2147483648;
    return r;
  endfunction

  task automatic check(input string req, input longint exp_v);
    longint got;
    got = longint'($signed(fixed_out));
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s code=%h mode=%0d actual=%h expected=%h", req, fp8_in, mode_e4m3,
               fixed_out, 32'(exp_v));
    end
  endtask

  task automatic apply(input bit [7:0] c, input bit md, input string req, input longint exp_v);
    @(posedge clk);
    #1;
    fp8_in = c;
    mode_e4m3 = md;
    @(negedge clk);
    check(req, exp_v);
  endtask

  initial begin
    #200us;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R5 initial", 0);

    // narrow-exponent format
    apply(8'h38, 1'b1, "R1 one",       64'h200);
    apply(8'h3D, 1'b1, "R1 1.625",     64'h340);
    apply(8'h01, 1'b1, "R3 min sub",   1);
    apply(8'h07, 1'b1, "R3 max sub",   7 * 64'd8 / 8 * 1);
    apply(8'h7F, 1'b1, "R8 top code",  64'h3C000);
    apply(8'hFF, 1'b1, "R6 neg top",   -64'sh3C000);
    apply(8'hB8, 1'b1, "R4 neg one",   -64'sh200);
    apply(8'h80, 1'b1, "R5 neg zero",  0);
    apply(8'h81, 1'b1, "R4 neg sub",   -1);
    // wide-exponent format
    apply(8'h3C, 1'b0, "R2 one",       64'h10000);
    apply(8'h01, 1'b0, "R3 min sub",   1);
    apply(8'h04, 1'b0, "R2 min normal",4);
    apply(8'h07, 1'b0, "R2 small",     7);
    apply(8'h77, 1'b0, "R2 largest",   64'h70000000);
    apply(8'h78, 1'b0, "R7 pos clamp", 64'h7FFFFFFF);
    apply(8'hF8, 1'b0, "R7 neg clamp", -64'sh80000000);
    apply(8'h7F, 1'b0, "R8 wide top",  64'h7FFFFFFF);
    apply(8'h80, 1'b0, "R5 neg zero",  0);
    apply(8'hBC, 1'b0, "R4 neg one",   -64'sh10000);
    // same-cycle response to a mode flip on one code
    apply(8'h40, 1'b1, "R9 narrow",    64'h400);
    apply(8'h40, 1'b0, "R9 wide",      64'h20000);

    // every code in both modes against the model
    for (int md = 0; md < 2; md++) begin
      for (int c = 0; c < 256; c++) begin
        apply(8'(c), 1'(md), (md == 1) ? "R1 sweep" : "R2 sweep", model(8'(c), 1'(md)));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule